// File: doc/BRIEF.md
# AC97-Style Controller Link Serializer

This block is the controller end of a five-wire audio link. The codec supplies the bit clock. The controller generates the frame sync. It shifts an outgoing frame onto the playback data line and rebuilds the incoming frame from the capture data line.

Each frame is 256 bit clocks long and has 13 slots. The first slot is a 16-bit tag. The remaining twelve slots carry 20 bits each. At a 12.288 MHz bit clock this gives a 48 kHz frame rate.

On the transmit side, a load strobe tells the user when the twelve outgoing slot words and their valid flags are taken. On the receive side, a one-bit-clock strobe marks that a complete frame of twelve slot words plus its tag is available. A separate output drives the codec's reset pin.

Top module: `ac97_link_ctrl`

## Requirements
- R1: A new frame starts every 256 rising bit-clock edges. A frame starts when `syncOut` goes from 0 to 1.
- R2: `syncOut` is high for exactly the first 16 bit clocks of a frame and low for the other 240.
- R3: Outgoing bits change on the rising edge. Bit k of a frame (k = 0 first) is presented after the k-th rising edge that follows the frame start. Order is the tag first, then slots 1 to 12, each sent MSB first. Slot n comes from `txSlotData[(n-1)*20 +: 20]`.
- R4: The outgoing tag holds the following. Bit 15 (sent first) is `txFrameValid`. Bit 15-n is `txSlotValid[n-1]` for slots n = 1..12. Bits 2..0 are zero.
- R5: A slot whose valid flag is 0 is sent as twenty zero bits.
- R6: The transmit inputs are taken at the rising edge during which `txLoad` is high. `txLoad` is high for one bit clock per frame: the last bit clock of the frame before. It is also high while reset is held.
- R7: `sdataIn` is sampled on falling edges, using the same bit positions as R3. `rxTag` and `rxSlotData` present the last complete frame, with slot n at `rxSlotData[(n-1)*20 +: 20]`.
- R8: `rxStrobe` rises on the falling edge that samples the final bit of slot 12. It stays high for exactly one bit clock. It pulses once per received frame, and the data outputs are already updated when it rises.
- R9: `codecRstN` is low while `rstN` is low. Otherwise it follows the inverse of `resetCodec` one rising edge later.
- R10: While `rstN` is low, `syncOut`, `sdataOut` and `rxStrobe` are 0. The first rising edge after release starts frame 0 with `syncOut` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock from the codec |
| rstN | input | 1 | Asynchronous active-low reset |
| resetCodec | input | 1 | Request to hold the codec in reset |
| codecRstN | output | 1 | Active-low reset line to the codec |
| syncOut | output | 1 | Frame sync to the codec |
| sdataOut | output | 1 | Serial playback data |
| sdataIn | input | 1 | Serial capture data |
| txFrameValid | input | 1 | Frame-valid flag for the outgoing tag |
| txSlotValid | input | 12 | Valid flag per outgoing slot, bit 0 = slot 1 |
| txSlotData | input | 240 | Outgoing slot words, 20 bits each |
| txLoad | output | 1 | Transmit inputs are taken at the next rising edge |
| rxTag | output | 16 | Tag of the last received frame |
| rxSlotData | output | 240 | Received slot words, 20 bits each |
| rxStrobe | output | 1 | One-bit-clock pulse when a received frame is complete |

## Verification
Outgoing bit k of a frame is valid from the k-th rising edge after the frame start, so the bench samples `syncOut` and `sdataOut` on falling edges. It rebuilds each frame from the sync rise and compares it with frames that the driver queued at the falling edge where `txLoad` was high. The codec model changes `sdataIn` just after each rising edge, so the design samples it half a cycle later. `rxStrobe` rises half a cycle after the final bit and is still high just after the next rising edge, which is where the bench pops the queued codec frame and compares it. `codecRstN` is checked at the falling edge after the rising edge that registers `resetCodec`.

// File: rtl/ac97_link_pkg.sv
package ac97_link_pkg;
  localparam int TAG_W  = 16;
  localparam int SLOT_W = 20;
  localparam int SLOT_N = 12;

  // Strobes from the frame control to the datapath
  typedef struct packed {
    logic loadFrame;  // next rising edge loads a new outgoing frame
    logic capLast;    // current bit is the last bit of the frame
  } linkStrobes_t;
endpackage

// File: rtl/ac97_frame_ctrl.sv
module ac97_frame_ctrl
  import ac97_link_pkg::*;
#(
  parameter int TAG_W  = ac97_link_pkg::TAG_W,
  parameter int SLOT_W = ac97_link_pkg::SLOT_W,
  parameter int SLOT_N = ac97_link_pkg::SLOT_N
) (
  input  logic         bitClk,
  input  logic         rstN,
  output linkStrobes_t strobes,
  output logic         syncOut
);
  localparam int FRAME_W = TAG_W + SLOT_N * SLOT_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(TAG_W);

  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitCntNext;
  logic             running;

  always_comb begin
    bitCntNext = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  end

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= LAST_BIT;
      running <= 1'b0;
      syncOut <= 1'b0;
    end else begin
      bitCnt  <= bitCntNext;
      running <= 1'b1;
      syncOut <= (bitCntNext < SYNC_END);
    end
  end

  always_comb begin
    strobes.loadFrame = (bitCnt == LAST_BIT);
    strobes.capLast   = running && (bitCnt == LAST_BIT);
  end

  // R2
  sync_width_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(syncOut) |-> bitCnt == SYNC_END);

  // R1
  frame_wrap_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    strobes.loadFrame |=> ($rose(syncOut) && bitCnt == '0));
endmodule

// File: rtl/ac97_frame_datapath.sv
module ac97_frame_datapath
  import ac97_link_pkg::*;
#(
  parameter int TAG_W  = ac97_link_pkg::TAG_W,
  parameter int SLOT_W = ac97_link_pkg::SLOT_W,
  parameter int SLOT_N = ac97_link_pkg::SLOT_N
) (
  input  logic                     bitClk,
  input  logic                     rstN,
  input  linkStrobes_t             strobes,
  input  logic                     txFrameValid,
  input  logic [SLOT_N-1:0]        txSlotValid,
  input  logic [SLOT_N*SLOT_W-1:0] txSlotData,
  input  logic                     sdataIn,
  output logic                     sdataOut,
  output logic [TAG_W-1:0]         rxTag,
  output logic [SLOT_N*SLOT_W-1:0] rxSlotData,
  output logic                     rxStrobe
);
  localparam int FRAME_W   = TAG_W + SLOT_N * SLOT_W;
  localparam int SLOT_BASE = FRAME_W - TAG_W - 1;
  localparam int PAD_W     = TAG_W - 1 - SLOT_N;

  logic [TAG_W-1:0]   tagWord;
  logic [FRAME_W-1:0] frameWord;
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-2:0] rxShift;
  logic [FRAME_W-1:0] rxFrame;

  // Outgoing tag: frame valid first, then one flag per slot, zero padding
  assign tagWord[TAG_W-1]   = txFrameValid;
  assign tagWord[PAD_W-1:0] = '0;
  assign frameWord[FRAME_W-1 -: TAG_W] = tagWord;

  for (genvar g = 0; g < SLOT_N; g++) begin : gSlot
    assign tagWord[TAG_W-2-g] = txSlotValid[g];
    assign frameWord[SLOT_BASE-g*SLOT_W -: SLOT_W] =
      txSlotValid[g] ? txSlotData[g*SLOT_W +: SLOT_W] : '0;
    assign rxSlotData[g*SLOT_W +: SLOT_W] = rxFrame[SLOT_BASE-g*SLOT_W -: SLOT_W];

    // R5
    invalid_slot_zero_chk: assert property (@(posedge bitClk) disable iff (!rstN)
      (strobes.loadFrame && !txSlotValid[g]) |=> txShift[SLOT_BASE-g*SLOT_W -: SLOT_W] == '0);
  end

  // Transmit shifter: load at frame start, shift out MSB first
  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobes.loadFrame) begin
      txShift <= frameWord;
    end else begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdataOut = txShift[FRAME_W-1];

  // Receive shifter: sampled on the falling edge
  always_ff @(negedge bitClk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      rxFrame  <= '0;
      rxStrobe <= 1'b0;
    end else begin
      rxShift  <= {rxShift[FRAME_W-3:0], sdataIn};
      rxStrobe <= strobes.capLast;
      if (strobes.capLast) begin
        rxFrame <= {rxShift, sdataIn};
      end
    end
  end

  assign rxTag = rxFrame[FRAME_W-1 -: TAG_W];

  // R8
  rx_pulse_chk: assert property (@(negedge bitClk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe);

  // R10
  always @(posedge bitClk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!sdataOut && !rxStrobe);
    end
  end
endmodule

// File: rtl/ac97_link_ctrl.sv
module ac97_link_ctrl
  import ac97_link_pkg::*;
#(
  parameter int TAG_W  = ac97_link_pkg::TAG_W,
  parameter int SLOT_W = ac97_link_pkg::SLOT_W,
  parameter int SLOT_N = ac97_link_pkg::SLOT_N
) (
  input  logic                     bitClk,
  input  logic                     rstN,
  input  logic                     resetCodec,
  output logic                     codecRstN,
  output logic                     syncOut,
  output logic                     sdataOut,
  input  logic                     sdataIn,
  input  logic                     txFrameValid,
  input  logic [SLOT_N-1:0]        txSlotValid,
  input  logic [SLOT_N*SLOT_W-1:0] txSlotData,
  output logic                     txLoad,
  output logic [TAG_W-1:0]         rxTag,
  output logic [SLOT_N*SLOT_W-1:0] rxSlotData,
  output logic                     rxStrobe
);
  linkStrobes_t strobes;

  ac97_frame_ctrl #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .SLOT_N(SLOT_N)) uCtrl (
    .bitClk  (bitClk),
    .rstN    (rstN),
    .strobes (strobes),
    .syncOut (syncOut)
  );

  ac97_frame_datapath #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .SLOT_N(SLOT_N)) uPath (
    .bitClk       (bitClk),
    .rstN         (rstN),
    .strobes      (strobes),
    .txFrameValid (txFrameValid),
    .txSlotValid  (txSlotValid),
    .txSlotData   (txSlotData),
    .sdataIn      (sdataIn),
    .sdataOut     (sdataOut),
    .rxTag        (rxTag),
    .rxSlotData   (rxSlotData),
    .rxStrobe     (rxStrobe)
  );

  assign txLoad = strobes.loadFrame;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      codecRstN <= 1'b0;
    end else begin
      codecRstN <= !resetCodec;
    end
  end

  // R9
  codec_reset_chk: assert property (@(posedge bitClk) disable iff (!rstN)
    resetCodec |=> !codecRstN);
endmodule

// File: tb/tb_ac97_link_ctrl.sv
module tb_ac97_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 16, SLOT_W = 20, SLOT_N = 12;
  localparam int FRAME_W = TAG_W + SLOT_N * SLOT_W;
  localparam int TX_FRAMES = 7;

  logic bitClk = 1'b0;
  logic rstN = 1'b1;
  logic resetCodec = 1'b0;
  logic codecRstN, syncOut, sdataOut, txLoad, rxStrobe;
  logic sdataIn = 1'b0;
  logic txFrameValid = 1'b0;
  logic [SLOT_N-1:0] txSlotValid = '0;
  logic [SLOT_N*SLOT_W-1:0] txSlotData = '0;
  logic [TAG_W-1:0] rxTag;
  logic [SLOT_N*SLOT_W-1:0] rxSlotData;

  int checks = 0, fails = 0;
  int txChecked = 0, rxChecked = 0, rxSent = 0;
  logic [FRAME_W-1:0] txExpQ[$];
  logic [FRAME_W-1:0] rxExpQ[$];

  always #(CLK_PERIOD/2) bitClk = ~bitClk;

  ac97_link_ctrl dut (
    .bitClk(bitClk), .rstN(rstN), .resetCodec(resetCodec), .codecRstN(codecRstN),
    .syncOut(syncOut), .sdataOut(sdataOut), .sdataIn(sdataIn),
    .txFrameValid(txFrameValid), .txSlotValid(txSlotValid), .txSlotData(txSlotData),
    .txLoad(txLoad), .rxTag(rxTag), .rxSlotData(rxSlotData), .rxStrobe(rxStrobe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Transmit patterns
  function automatic logic [11:0] validOf(int k);
    case (k)
      0: return 12'hFFF;
      1: return 12'h000;
      2: return 12'hA5A;
      3: return 12'h801;
      4: return 12'hFFF;
      5: return 12'h3C3;
      default: return 12'hFFF;
    endcase
  endfunction

  function automatic logic [19:0] dataOf(int k, int n);
    if (k == 4) return 20'hFFFFF;
    return 20'(k * 32'h1D35B + n * 32'h0A3C7 + 32'h10001);
  endfunction

  // Expected frame: tag {fv, slot1..slot12 valid, 000}, then slots 1..12
  function automatic logic [FRAME_W-1:0] expTx(int k);
    logic [FRAME_W-1:0] f;
    logic [11:0] v;
    v = validOf(k);
    f = FRAME_W'(k != 1);
    for (int n = 0; n < SLOT_N; n++) f = (f << 1) | FRAME_W'(v[n]);
    f = f << 3;
    for (int n = 0; n < SLOT_N; n++) f = (f << 20) | FRAME_W'(v[n] ? dataOf(k, n) : 20'h0);
    return f;
  endfunction

  task automatic applyTx(int k);
    txFrameValid = (k != 1);
    txSlotValid = validOf(k);
    for (int n = 0; n < SLOT_N; n++) txSlotData[n*SLOT_W +: SLOT_W] = dataOf(k, n);
    txExpQ.push_back(expTx(k));
  endtask

  function automatic logic [FRAME_W-1:0] makeRx(int j);
    logic [FRAME_W-1:0] f;
    f = FRAME_W'(16'(j * 32'h9C31 ^ 32'h8001));
    for (int n = 0; n < SLOT_N; n++)
      f = (f << 20) | FRAME_W'(20'(j * 32'h2F1B7 ^ n * 32'h51A3 ^ 32'hC3C3C));
    return f;
  endfunction

  // Driver: hands a new frame to the design whenever txLoad is seen
  task automatic driveFrames();
    for (int k = 1; k < TX_FRAMES; k++) begin
      @(negedge bitClk);
      while (!txLoad) @(negedge bitClk);
      applyTx(k);
      @(negedge bitClk);
      check(txLoad == 1'b0, "R6", "txLoad one bit clock wide", 32'(txLoad), 32'h0);
    end
  endtask

  task automatic codecResetTest();
    repeat (300) @(negedge bitClk);
    check(codecRstN == 1'b1, "R9", "codecRstN idle", 32'(codecRstN), 32'h1);
    resetCodec = 1'b1;
    @(negedge bitClk);
    check(codecRstN == 1'b0, "R9", "codecRstN asserted", 32'(codecRstN), 32'h0);
    resetCodec = 1'b0;
    @(negedge bitClk);
    check(codecRstN == 1'b1, "R9", "codecRstN released", 32'(codecRstN), 32'h1);
  endtask

  // Transmit monitor
  logic [FRAME_W-1:0] txGot;
  int txIdx = 0;
  int syncBad = 0;
  bit txStarted = 0;
  logic txPrevSync = 1'b0;

  always @(negedge bitClk) begin
    if (!rstN) begin
      txStarted = 0;
      txPrevSync = 1'b0;
    end else begin
      if (syncOut && !txPrevSync) begin
        if (txStarted) check(txIdx == FRAME_W, "R1", "frame length", 32'(txIdx), 32'(FRAME_W));
        txStarted = 1;
        txIdx = 0;
        syncBad = 0;
      end
      txPrevSync = syncOut;
      if (txStarted && txIdx < FRAME_W) begin
        txGot[FRAME_W-1-txIdx] = sdataOut;
        if (syncOut != (txIdx < TAG_W)) syncBad++;
        txIdx++;
        if (txIdx == FRAME_W && txExpQ.size() > 0) begin
          logic [FRAME_W-1:0] e;
          e = txExpQ.pop_front();
          txChecked++;
          check(syncBad == 0, "R2", "sync high in tag slot only", 32'(syncBad), 32'h0);
          check(txGot[FRAME_W-1 -: TAG_W] == e[FRAME_W-1 -: TAG_W], "R4", "tag",
                32'(txGot[FRAME_W-1 -: TAG_W]), 32'(e[FRAME_W-1 -: TAG_W]));
          for (int n = 0; n < SLOT_N; n++) begin
            logic [19:0] g, x;
            g = 20'(txGot >> (20 * (SLOT_N - 1 - n)));
            x = 20'(e >> (20 * (SLOT_N - 1 - n)));
            if (x == 20'h0) check(g == x, "R5", "slot zero fill", 32'(g), 32'(x));
            else check(g == x, "R3", "slot data", 32'(g), 32'(x));
          end
        end
      end
    end
  end

  // Codec model: drives capture data just after each rising edge
  logic [FRAME_W-1:0] rxCur = '0;
  int rxIdx = 0;
  bit rxStarted = 0;
  logic rxPrevSync = 1'b0;

  always @(posedge bitClk) begin
    #1;
    if (!rstN) begin
      sdataIn = 1'b0;
      rxStarted = 0;
      rxPrevSync = 1'b0;
    end else begin
      if (syncOut && !rxPrevSync) begin
        rxCur = makeRx(rxSent);
        rxSent++;
        rxExpQ.push_back(rxCur);
        rxIdx = 0;
        rxStarted = 1;
      end
      rxPrevSync = syncOut;
      if (rxStarted && rxIdx < FRAME_W) begin
        sdataIn = rxCur[FRAME_W-1-rxIdx];
        rxIdx++;
      end
    end
  end

  // Receive monitor
  always @(posedge bitClk) begin
    #2;
    if (rstN && rxStrobe) begin
      if (rxExpQ.size() == 0) begin
        check(1'b0, "R8", "strobe without frame", 32'h1, 32'h0);
      end else begin
        logic [FRAME_W-1:0] e;
        e = rxExpQ.pop_front();
        rxChecked++;
        check(rxTag == e[FRAME_W-1 -: TAG_W], "R7", "rx tag",
              32'(rxTag), 32'(e[FRAME_W-1 -: TAG_W]));
        for (int n = 0; n < SLOT_N; n++) begin
          logic [19:0] x;
          x = 20'(e >> (20 * (SLOT_N - 1 - n)));
          check(rxSlotData[n*SLOT_W +: SLOT_W] == x, "R7", "rx slot",
                32'(rxSlotData[n*SLOT_W +: SLOT_W]), 32'(x));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge bitClk);
    check(1'b0, "watchdog", "run timed out", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    applyTx(0);
    #2 rstN = 1'b0;
    repeat (3) @(negedge bitClk);
    #1;
    check(syncOut == 1'b0, "R10", "sync in reset", 32'(syncOut), 32'h0);
    check(sdataOut == 1'b0, "R10", "sdataOut in reset", 32'(sdataOut), 32'h0);
    check(rxStrobe == 1'b0, "R10", "rxStrobe in reset", 32'(rxStrobe), 32'h0);
    check(codecRstN == 1'b0, "R9", "codecRstN in reset", 32'(codecRstN), 32'h0);
    check(txLoad == 1'b1, "R6", "txLoad in reset", 32'(txLoad), 32'h1);
    rstN = 1'b1;
    @(posedge bitClk);
    #1;
    check(syncOut == 1'b1, "R10", "first frame starts", 32'(syncOut), 32'h1);
    fork
      driveFrames();
      codecResetTest();
    join
    wait (txChecked >= TX_FRAMES && rxChecked >= TX_FRAMES);
    @(negedge bitClk);
    #1;
    check(rxChecked == rxSent - 1, "R8", "one strobe per frame", 32'(rxChecked), 32'(rxSent - 1));
    rstN = 1'b0;
    #1;
    check(syncOut == 1'b0, "R10", "sync after reset", 32'(syncOut), 32'h0);
    check(sdataOut == 1'b0, "R10", "sdataOut after reset", 32'(sdataOut), 32'h0);
    check(rxStrobe == 1'b0, "R10", "rxStrobe after reset", 32'(rxStrobe), 32'h0);
    finishRun();
  end
endmodule